// File: doc/BRIEF.md
# Serial Receive Queue with In-Band Break Marking

This block buffers incoming serial characters between the receive shifter and the register interface. Each character is stored as a 12-bit word. Bits 7:0 hold the data, and the upper bits are zero. A line break is stored as its own word, with bit 10 set and the data bits zero. This keeps the break in order with the characters around it. Storage is a circular queue that uses a read pointer and an occupancy count. A new word goes into the slot found by adding the count to the pointer, wrapping around at the queue depth.

A mode input selects one of two accept depths. With the mode on, the queue accepts words up to its full depth. With the mode off, it holds only one word. A push that arrives while input is refused is dropped and raises an overrun pulse. The data-register read is modelled as a `pop` strobe. The word at the read pointer is shown on `pop_data` in the same cycle. The block keeps the empty flag, the full flag and a raw receive interrupt. The interrupt trigger level is fixed by a parameter, which defaults to one word.

Top module: `uart_rxq`

## Requirements
- R1: After reset, `rx_empty`=1, `rx_full`=0, `rx_irq`=0, `overrun`=0 and `accept`=1.
- R2: Words pop out in push order. A character push stores `{4'h0, push_data}`, and `pop_data` shows the word at the read pointer before the popping edge.
- R3: A push with `push_brk`=1 stores the word 12'h400 (bit 10 set, all other bits zero), whatever `push_data` holds.
- R4: With `fifo_en`=1, `accept` is 1 while the count is below 16. With `fifo_en`=0, `accept` is 1 only while the count is 0.
- R5: A push offered while `accept`=0 is dropped and is not stored. `overrun` is 1 for the cycle after that edge and 0 after an edge with no refused push.
- R6: A pop while the queue is empty does not move the read pointer. A second empty pop shows the same `pop_data`, and the next pushed word is read back by the next pop.
- R7: `rx_empty` is 1 exactly when the count is zero. It clears on any push and sets on a pop that leaves the count at zero.
- R8: `rx_full` sets on a push that brings the count to 16, or on any push while `full_every_push`=1. A pop clears it unless the same edge sets it.
- R9: `rx_irq` sets on a push that brings the count to the trigger level (1), and clears on a pop that leaves the count one below it.
- R10: A push and a pop accepted on the same edge leave the count unchanged. The flags then match that count.
- R11: The read and write positions wrap modulo 16, so the order is kept across the end of the storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1: full-depth buffering, 0: single-word holding |
| full_every_push | input | 1 | When 1, every accepted push sets the full flag |
| push_valid | input | 1 | Word offered by the receive shifter this cycle |
| push_brk | input | 1 | Offered word is a break marker |
| push_data | input | 8 | Received character |
| pop | input | 1 | Data-register read strobe |
| pop_data | output | 12 | Word at the read pointer |
| accept | output | 1 | The queue can take a word this cycle |
| rx_empty | output | 1 | Queue empty flag |
| rx_full | output | 1 | Queue full flag |
| rx_irq | output | 1 | Raw receive interrupt |
| overrun | output | 1 | One-cycle pulse after a refused push |

## Verification
A short vector table mixes character pushes, a break push, a push and a pop on the same edge, and pops on an empty queue. It shows whether the break marker, the same-edge count and the stale read are each handled in their own way. A fill to depth that starts at a nonzero pointer offset, followed by a drain, separates correct wrap order from an off-by-one in the slot arithmetic. It also shows the point where the full flag rises and the refused push is dropped. Single-word mode and the forced-full input are run as separate patterns. This keeps an error in the accept limit apart from an error in the flag rules.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
  localparam int WORD_W = 12;
  localparam int CHAR_W = 8;
  localparam logic [WORD_W-1:0] BRK_WORD = 12'h400;

  typedef logic [WORD_W-1:0] rxq_word_t;

  // Build the stored word from a character or a break event.
  function automatic rxq_word_t make_word(input logic brk, input logic [CHAR_W-1:0] ch);
    return brk ? BRK_WORD : {{(WORD_W-CHAR_W){1'b0}}, ch};
  endfunction

  // Ring position of base+offs within a ring of the given depth.
  function automatic int ring_add(input int base, input int offs, input int depth);
    int s;
    s = base + offs;
    if (s >= depth) s = s - depth;
    return s;
  endfunction

  // Occupancy after one edge.
  function automatic int occ_next(input int occ, input logic put, input logic take);
    return occ + (put ? 1 : 0) - (take ? 1 : 0);
  endfunction
endpackage

// File: rtl/uart_rxq_mem.sv
module uart_rxq_mem
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  rxq_word_t       wdata,
  input  logic [AW-1:0]   raddr,
  output rxq_word_t       rdata
);
  rxq_word_t slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         slot_q[g] <= '0;
      else if (we && waddr == AW'(g))     slot_q[g] <= wdata;
    end
  end

  assign rdata = slot_q[raddr];
endmodule

// File: rtl/uart_rxq_ctl.sv
module uart_rxq_ctl
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          push_valid,
  input  logic          pop,
  output logic          accept,
  output logic          push_ok,
  output logic          pop_ok,
  output logic [AW-1:0] rd_ptr,
  output logic [AW-1:0] wr_slot,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_nxt,
  output logic          overrun
);
  logic [CW-1:0] limit;

  assign limit   = fifo_en ? CW'(DEPTH) : CW'(1);
  assign accept  = cnt_q < limit;
  assign push_ok = push_valid && accept;
  assign pop_ok  = pop && (cnt_q != '0);
  assign cnt_nxt = CW'(occ_next(int'(cnt_q), push_ok, pop_ok));
  assign wr_slot = AW'(ring_add(int'(rd_ptr), int'(cnt_q), DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      rd_ptr  <= '0;
      overrun <= 1'b0;
    end else begin
      cnt_q   <= cnt_nxt;
      overrun <= push_valid && !accept;
      if (pop_ok) rd_ptr <= AW'(ring_add(int'(rd_ptr), 1, DEPTH));
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH)) else $error("count above depth"); // R4
  AST_OVR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !accept) |=> overrun) else $error("refused push without overrun"); // R5
  AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && cnt_q == '0) |=> $stable(rd_ptr)) else $error("pointer moved on empty pop"); // R6
  AST_SAME_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok) |=> $stable(cnt_q)) else $error("count moved on push+pop"); // R10
endmodule

// File: rtl/uart_rxq_flags.sv
module uart_rxq_flags #(
  parameter int DEPTH = 16,
  parameter int TRIG  = 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_ok,
  input  logic          pop,
  input  logic [CW-1:0] cnt_nxt,
  input  logic          full_every_push,
  output logic          rx_empty,
  output logic          rx_full,
  output logic          rx_irq
);
  logic set_empty, set_full, set_irq, clr_irq;

  assign set_empty = pop && (cnt_nxt == '0);
  assign set_full  = push_ok && (full_every_push || cnt_nxt == CW'(DEPTH));
  assign set_irq   = push_ok && (cnt_nxt == CW'(TRIG));
  assign clr_irq   = pop && (cnt_nxt == CW'(TRIG - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_empty <= 1'b1;
      rx_full  <= 1'b0;
      rx_irq   <= 1'b0;
    end else begin
      if (push_ok)        rx_empty <= 1'b0;
      else if (set_empty) rx_empty <= 1'b1;
      if (set_full)       rx_full  <= 1'b1;
      else if (pop)       rx_full  <= 1'b0;
      if (set_irq)        rx_irq   <= 1'b1;
      else if (clr_irq)   rx_irq   <= 1'b0;
    end
  end

  AST_FULL_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $past(push_ok)) else $error("full rose without push"); // R8
  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_irq) |-> $past(push_ok)) else $error("irq rose without push"); // R9
endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TRIG  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic              full_every_push,
  input  logic              push_valid,
  input  logic              push_brk,
  input  logic [CHAR_W-1:0] push_data,
  input  logic              pop,
  output logic [WORD_W-1:0] pop_data,
  output logic              accept,
  output logic              rx_empty,
  output logic              rx_full,
  output logic              rx_irq,
  output logic              overrun
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic          push_ok, pop_ok;
  logic [AW-1:0] rd_ptr, wr_slot;
  logic [CW-1:0] cnt_q, cnt_nxt;
  rxq_word_t     in_word;

  assign in_word = make_word(push_brk, push_data);

  uart_rxq_ctl #(.DEPTH(DEPTH)) ctl_i (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .push_valid(push_valid), .pop(pop),
    .accept(accept), .push_ok(push_ok), .pop_ok(pop_ok), .rd_ptr(rd_ptr),
    .wr_slot(wr_slot), .cnt_q(cnt_q), .cnt_nxt(cnt_nxt), .overrun(overrun)
  );

  uart_rxq_mem #(.DEPTH(DEPTH)) mem_i (
    .clk(clk), .rst_n(rst_n), .we(push_ok), .waddr(wr_slot), .wdata(in_word),
    .raddr(rd_ptr), .rdata(pop_data)
  );

  uart_rxq_flags #(.DEPTH(DEPTH), .TRIG(TRIG)) flags_i (
    .clk(clk), .rst_n(rst_n), .push_ok(push_ok), .pop(pop), .cnt_nxt(cnt_nxt),
    .full_every_push(full_every_push), .rx_empty(rx_empty), .rx_full(rx_full), .rx_irq(rx_irq)
  );

  AST_EMPTY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty == (cnt_q == '0)) else $error("empty flag disagrees with count"); // R7
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq == (cnt_q >= CW'(TRIG))) else $error("irq disagrees with count"); // R9
  AST_POP_ONLY_WHEN_FILLED: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |=> !$past(rx_empty)) else $error("pop taken from empty queue"); // R6
endmodule

// File: tb/uart_rxq_tb.sv
`timescale 1ns/1ps
module uart_rxq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fifo_en = 1'b1, full_every_push = 1'b0;
  logic        push_valid = 1'b0, push_brk = 1'b0, pop = 1'b0;
  logic [7:0]  push_data = '0;
  logic [11:0] pop_data;
  logic        accept, rx_empty, rx_full, rx_irq, overrun;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [11:0] pre_data;
  logic        pre_acc;

  always #2.5 clk = ~clk;

  uart_rxq dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .full_every_push(full_every_push),
    .push_valid(push_valid), .push_brk(push_brk), .push_data(push_data), .pop(pop),
    .pop_data(pop_data), .accept(accept), .rx_empty(rx_empty), .rx_full(rx_full),
    .rx_irq(rx_irq), .overrun(overrun)
  );

  task automatic chk(input string tag, input logic [11:0] got, input logic [11:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input logic pv, input logic brk, input logic [7:0] d, input logic pp);
    push_valid = pv; push_brk = brk; push_data = d; pop = pp;
    @(negedge clk);
    pre_data = pop_data;
    pre_acc  = accept;
    @(posedge clk); #1;
    push_valid = 0; push_brk = 0; pop = 0;
  endtask

  // {push, brk, data[7:0], pop, chk_data, exp_data[11:0], exp_empty, exp_full, exp_irq}
  localparam logic [26:0] VEC [6] = '{
    {1'b1, 1'b0, 8'h41, 1'b0, 1'b0, 12'h000, 3'b001},
    {1'b1, 1'b1, 8'h77, 1'b0, 1'b0, 12'h000, 3'b001},
    {1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 12'h041, 3'b001},
    {1'b1, 1'b0, 8'h5A, 1'b1, 1'b1, 12'h400, 3'b001},
    {1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 12'h05A, 3'b100},
    {1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 12'h000, 3'b100}
  };

  initial begin
    #20000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [11:0] a, b;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 empty", {11'h0, rx_empty}, 12'h1);
    chk("R1 full", {11'h0, rx_full}, 12'h0);
    chk("R1 irq", {11'h0, rx_irq}, 12'h0);
    chk("R1 overrun", {11'h0, overrun}, 12'h0);
    chk("R1 accept", {11'h0, accept}, 12'h1);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // Vector table: R2 order, R3 break word, R9 irq, R10 same-edge, R6 empty pop, R7 empty
    for (int i = 0; i < 6; i++) begin
      step(VEC[i][26], VEC[i][25], VEC[i][24:17], VEC[i][16]);
      if (VEC[i][15]) chk($sformatf("R2/R3 vec%0d data", i), pre_data, VEC[i][14:3]);
      chk($sformatf("R7 vec%0d empty", i), {11'h0, rx_empty}, {11'h0, VEC[i][2]});
      chk($sformatf("R10 vec%0d full", i), {11'h0, rx_full}, {11'h0, VEC[i][1]});
      chk($sformatf("R9 vec%0d irq", i), {11'h0, rx_irq}, {11'h0, VEC[i][0]});
    end

    // Fill to depth from a nonzero pointer offset: R4, R8, R11
    for (int i = 0; i < 16; i++) begin
      step(1, 0, 8'h80 + 8'(i), 0);
      if (i == 14) chk("R8 not full at 15", {11'h0, rx_full}, 12'h0);
    end
    chk("R8 full at 16", {11'h0, rx_full}, 12'h1);
    chk("R4 accept low at 16", {11'h0, accept}, 12'h0);
    step(1, 0, 8'hEE, 0);
    chk("R5 overrun pulse", {11'h0, overrun}, 12'h1);
    step(0, 0, 8'h00, 0);
    chk("R5 overrun ends", {11'h0, overrun}, 12'h0);
    for (int i = 0; i < 16; i++) begin
      step(0, 0, 8'h00, 1);
      chk($sformatf("R11 wrap order %0d", i), pre_data, 12'h080 + 12'(i));
      if (i == 0) chk("R8 full cleared by pop", {11'h0, rx_full}, 12'h0);
    end
    chk("R5 dropped word absent", {11'h0, rx_empty}, 12'h1);
    chk("R9 irq cleared at zero", {11'h0, rx_irq}, 12'h0);

    // Empty pops leave pointer in place: R6
    step(0, 0, 8'h00, 1); a = pre_data;
    step(0, 0, 8'h00, 1); b = pre_data;
    chk("R6 stale data repeats", b, a);
    chk("R6 still empty", {11'h0, rx_empty}, 12'h1);
    step(1, 0, 8'h33, 0);
    step(0, 0, 8'h00, 1);
    chk("R6 next push read back", pre_data, 12'h033);

    // Single-word mode: R4, R5
    fifo_en = 1'b0;
    step(1, 0, 8'h11, 0);
    chk("R4 accept low in single mode", {11'h0, accept}, 12'h0);
    step(1, 0, 8'h22, 0);
    chk("R5 overrun in single mode", {11'h0, overrun}, 12'h1);
    step(0, 0, 8'h00, 1);
    chk("R4 held word", pre_data, 12'h011);
    chk("R5 second word dropped", {11'h0, rx_empty}, 12'h1);
    fifo_en = 1'b1;

    // Forced full on any push: R8
    full_every_push = 1'b1;
    step(1, 0, 8'h44, 0);
    chk("R8 forced full", {11'h0, rx_full}, 12'h1);
    full_every_push = 1'b0;
    step(0, 0, 8'h00, 1);
    chk("R8 pop clears forced full", {11'h0, rx_full}, 12'h0);
    chk("R3 char word upper bits zero", pre_data, 12'h044);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule